// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block is a hardware master that programs a target FPGA through its serial configuration port. On a start pulse it puts the target into reset with the chip select held low. It then lets the target out of reset and checks that the target's done line is still low. Next it waits out the target's internal housekeeping interval and drops the select for one cycle. After that it streams the bitstream bytes it receives on a valid/ready byte interface out as SPI mode 0.

When the stream's last byte has left the shifter, the loader checks that the target raised its done line. If it did, the loader clocks out a run of zero bytes that start the loaded design, then reports success. The block reports three error codes: a failed reset, a target that never finished, and a partial-reconfiguration request. A partial request is refused at once and leaves the target's pins alone. All timing comes from parameters given in system clock cycles, derived from the clock frequency. The done input crosses into the clock domain through a two-flop synchronizer.

Top module: `spi_cfg_loader`

## Requirements
- R1: A start pulse without the partial flag drives the target reset low and chip select low together, and both stay low for at least the reset hold time (RST_HOLD_NS, converted to cycles; 1 µs by default). Reset is never low while chip select is high.
- R2: Reset is released while chip select stays low. After a short settling wait, the synchronized done input is tested. If it reads high, the load ends with err_o and error code 1, chip select goes high, and no stream byte is requested.
- R3: After reset is released, chip select stays low for at least the housekeeping time (HOUSE_US microseconds in cycles). It then goes high for at least one cycle before the first serial clock edge of the bitstream.
- R4: Bytes are shifted MSB first in SPI mode 0. The serial clock idles low, and data is stable at each rising edge. Rising edges inside a byte are 2*SCK_HALF_DIV system cycles apart. The resulting serial clock must lie between 1 MHz and 25 MHz.
- R5: A stream byte is accepted (s_valid_i and s_ready_o high on a clock edge) only when the shifter is empty, so successive accepted bytes are separated by exactly eight serial clock rising edges. Chip select is low during every serial clock edge.
- R6: Once the byte flagged s_last_i has been shifted out, the done input is tested again. If it reads low, the load ends with err_o and error code 2, and no further serial clock edges are produced.
- R7: If done reads high at that point, ACT_BYTES (default 7) zero bytes are clocked out. Then chip select goes high and ok_o pulses with error code 0. ok_o and err_o are never high together.
- R8: A start pulse with partial_i high gives err_o with error code 3 on the next cycle. busy_o stays low, and reset, chip select and the serial clock do not change.
- R9: After reset, busy_o is low, reset and chip select are high, and the serial clock is low. busy_o is high from the cycle after start until the cycle in which ok_o or err_o is high. Start pulses while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a load |
| partial_i | input | 1 | Marks the request as partial reconfiguration |
| s_valid_i | input | 1 | Bitstream byte valid |
| s_data_i | input | 8 | Bitstream byte |
| s_last_i | input | 1 | Marks the final bitstream byte |
| s_ready_o | output | 1 | Loader can take a byte |
| cfg_rst_n_o | output | 1 | Target reset, active low |
| cfg_cs_n_o | output | 1 | Target chip select, active low |
| cfg_sck_o | output | 1 | Serial clock to target |
| cfg_mosi_o | output | 1 | Serial data to target |
| cfg_done_i | input | 1 | Target done indication (asynchronous) |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Single-cycle success pulse |
| err_o | output | 1 | Single-cycle error pulse |
| err_code_o | output | 2 | Result code: 0 none, 1 reset failed, 2 not done, 3 partial refused |

## Verification
Some results have a fixed latency. The partial-request error and the rise of busy appear one cycle after start, so the bench samples them at the next falling edge. Other results depend on the programmed waits: the reset-check error comes RST_CYC plus the settle wait plus two cycles after start, and success comes after the full serial transfer. For these, the bench waits for the ok or err pulse under a bounded timeout and then checks the code and busy in that same cycle. A monitor samples the pins on every falling edge and measures the reset and housekeeping spans. It rebuilds each byte from the serial clock's rising edges and compares it with the byte the driver queued. Any bytes after the queue is empty are counted as activation bytes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_CHKRST,
    ST_HKEEP,
    ST_GAP,
    ST_XFER,
    ST_CHKDONE,
    ST_ACT
  } ld_state_e;

  typedef enum logic [1:0] {
    CODE_NONE    = 2'd0,
    CODE_RESET   = 2'd1,
    CODE_NOTDONE = 2'd2,
    CODE_PARTIAL = 2'd3
  } ld_code_e;

  localparam int unsigned SCK_MIN_HZ = 1_000_000;
  localparam int unsigned SCK_MAX_HZ = 25_000_000;

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = value_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R1: a loaded count never grows without a new load
  a_r1_timer_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       idle_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [7:0]    sh_q, sh_d;
  logic [3:0]    bits_q, bits_d;
  logic [DW-1:0] div_q, div_d;
  logic          sck_q, sck_d;

  always_comb begin
    sh_d   = sh_q;
    bits_d = bits_q;
    div_d  = div_q;
    sck_d  = sck_q;
    if (bits_q == 4'd0) begin
      if (load_i) begin
        sh_d   = data_i;
        bits_d = 4'd8;
        div_d  = '0;
        sck_d  = 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
      end else begin
        sck_d  = 1'b0;
        sh_d   = {sh_q[6:0], 1'b0};
        bits_d = bits_q - 4'd1;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bits_q <= '0;
      div_q  <= '0;
      sck_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bits_q <= bits_d;
      div_q  <= div_d;
      sck_q  <= sck_d;
    end
  end

  assign idle_o = (bits_q == 4'd0);
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];

  // R4: data holds steady across every rising serial clock edge
  a_r4_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> $stable(mosi_o));
  // R4: clock rests low whenever no byte is in flight
  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !sck_o);
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned SCK_HALF_DIV = 2,
  parameter int unsigned RST_HOLD_NS  = 1000,
  parameter int unsigned HOUSE_US     = 1200,
  parameter int unsigned ACT_BYTES    = 7,
  parameter int unsigned SETTLE_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  output logic       cfg_rst_n_o,
  output logic       cfg_cs_n_o,
  output logic       cfg_sck_o,
  output logic       cfg_mosi_o,
  input  logic       cfg_done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  localparam longint RST_CYC_L = (longint'(CLK_HZ) * longint'(RST_HOLD_NS)
                                  + 64'sd999_999_999) / 64'sd1_000_000_000;
  localparam longint HK_CYC_L  = (longint'(CLK_HZ) / 64'sd1_000_000) * longint'(HOUSE_US);
  localparam int unsigned RST_CYC = int'(RST_CYC_L);
  localparam int unsigned HK_CYC  = int'(HK_CYC_L);
  localparam int unsigned SCK_HZ  = CLK_HZ / (2 * SCK_HALF_DIV);
  localparam int unsigned TMR_MAX = (HK_CYC > RST_CYC) ?
                                    ((HK_CYC > SETTLE_CYC) ? HK_CYC : SETTLE_CYC) :
                                    ((RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC);
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned ACT_W   = $clog2(ACT_BYTES + 1);

  generate
    if (SCK_HZ < SCK_MIN_HZ || SCK_HZ > SCK_MAX_HZ) begin : g_bad_sck
      $error("serial clock rate outside permitted range");
    end
  endgenerate

  ld_state_e        state_q, state_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic             last_q, last_d;
  logic             ok_q, ok_d;
  logic             err_q, err_d;
  ld_code_e         code_q, code_d;
  logic             rstn_q, rstn_d;
  logic             csn_q, csn_d;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_exp;
  logic             shf_load;
  logic [7:0]       shf_byte;
  logic             shf_idle;
  logic             done_s;

  cfgld_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cfg_done_i), .sync_o(done_s)
  );

  cfgld_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .value_i(tmr_val),
    .expired_o(tmr_exp)
  );

  cfgld_shift #(.HALF_DIV(SCK_HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(shf_load), .data_i(shf_byte),
    .idle_o(shf_idle), .sck_o(cfg_sck_o), .mosi_o(cfg_mosi_o)
  );

  always_comb begin
    state_d  = state_q;
    act_d    = act_q;
    last_d   = last_q;
    code_d   = code_q;
    ok_d     = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    shf_load = 1'b0;
    shf_byte = 8'h00;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (partial_i) begin
            err_d  = 1'b1;
            code_d = CODE_PARTIAL;
          end else begin
            state_d  = ST_HOLD;
            code_d   = CODE_NONE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(RST_CYC);
          end
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          state_d  = ST_CHKRST;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SETTLE_CYC);
        end
      end
      ST_CHKRST: begin
        if (tmr_exp) begin
          if (done_s) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
            code_d  = CODE_RESET;
          end else begin
            state_d  = ST_HKEEP;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(HK_CYC);
          end
        end
      end
      ST_HKEEP: begin
        if (tmr_exp) state_d = ST_GAP;
      end
      ST_GAP: begin
        state_d = ST_XFER;
        last_d  = 1'b0;
      end
      ST_XFER: begin
        if (shf_idle) begin
          if (last_q) begin
            state_d  = ST_CHKDONE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(SETTLE_CYC);
          end else if (s_valid_i) begin
            shf_load = 1'b1;
            shf_byte = s_data_i;
            last_d   = s_last_i;
          end
        end
      end
      ST_CHKDONE: begin
        if (tmr_exp) begin
          if (done_s) begin
            state_d = ST_ACT;
            act_d   = ACT_W'(ACT_BYTES);
          end else begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
            code_d  = CODE_NOTDONE;
          end
        end
      end
      ST_ACT: begin
        if (shf_idle) begin
          if (act_q == '0) begin
            state_d = ST_IDLE;
            ok_d    = 1'b1;
          end else begin
            shf_load = 1'b1;
            act_d    = act_q - 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    rstn_d = (state_d != ST_HOLD);
    csn_d  = !(state_d inside {ST_HOLD, ST_CHKRST, ST_HKEEP, ST_XFER,
                               ST_CHKDONE, ST_ACT});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      last_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= CODE_NONE;
      rstn_q  <= 1'b1;
      csn_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      last_q  <= last_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      code_q  <= code_d;
      rstn_q  <= rstn_d;
      csn_q   <= csn_d;
    end
  end

  assign s_ready_o   = (state_q == ST_XFER) && shf_idle && !last_q;
  assign cfg_rst_n_o = rstn_q;
  assign cfg_cs_n_o  = csn_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign ok_o        = ok_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;

  // R1: target reset only while selected
  a_r1_rst_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n_o |-> !cfg_cs_n_o);
  // R5: every serial clock pulse falls inside a selected window
  a_r5_sck_selected: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sck_o |-> !cfg_cs_n_o);
  // R7: success and failure never reported together
  a_r7_ok_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && err_o));
  // R8: a refused partial request leaves the pins released and the block idle
  a_r8_partial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && err_code_o == 2'd3) |-> (!busy_o && cfg_cs_n_o && cfg_rst_n_o));
  // R9: idle means all target pins released
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cfg_cs_n_o && cfg_rst_n_o && !cfg_sck_o));
  // R6: after a not-done error the serial clock is quiet
  a_r6_notdone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && err_code_o == 2'd2) |-> !cfg_sck_o);
endmodule

// File: tb/spi_cfg_loader_tb_top.sv
module spi_cfg_loader_tb_top;
  localparam int unsigned RST_CYC = 100;
  localparam int unsigned HK_CYC  = 200;
  localparam int unsigned HALF    = 2;
  localparam int unsigned NACT    = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, partial_i, s_valid_i, s_last_i;
  logic [7:0] s_data_i;
  logic s_ready_o, cfg_rst_n_o, cfg_cs_n_o, cfg_sck_o, cfg_mosi_o, cfg_done_i;
  logic busy_o, ok_o, err_o;
  logic [1:0] err_code_o;

  always #5 clk = ~clk;

  spi_cfg_loader #(
    .CLK_HZ(100_000_000), .SCK_HALF_DIV(HALF), .RST_HOLD_NS(1000),
    .HOUSE_US(2), .ACT_BYTES(NACT), .SETTLE_CYC(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
    .s_ready_o(s_ready_o), .cfg_rst_n_o(cfg_rst_n_o), .cfg_cs_n_o(cfg_cs_n_o),
    .cfg_sck_o(cfg_sck_o), .cfg_mosi_o(cfg_mosi_o), .cfg_done_i(cfg_done_i),
    .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard and pin monitor
  logic [7:0] exp_q[$];
  int act_cnt, bitpos, rst_falls, rst_low_len, hk_len, rel_cyc, last_rise;
  int rises_since_hs, hs_cnt;
  bit ready_seen, rel_pending, cs_gap_seen, any_rise_since_rel;
  logic [7:0] acc;
  logic p_rst, p_cs, p_sck;

  task automatic clear_mon();
    act_cnt = 0; bitpos = 0; rst_falls = 0; rst_low_len = 0; hk_len = 0;
    hs_cnt = 0; rises_since_hs = 0; ready_seen = 0; rel_pending = 0;
    cs_gap_seen = 0; any_rise_since_rel = 0; exp_q.delete();
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cfg_rst_n_o) rst_low_len++;
      if (p_rst && !cfg_rst_n_o) begin rst_falls++; rst_low_len = 1; end
      if (!p_rst && cfg_rst_n_o) begin
        chk(cfg_cs_n_o == 1'b0, "R2 cs low at reset release", cfg_cs_n_o, 0);
        rel_cyc = cyc; rel_pending = 1; any_rise_since_rel = 0;
      end
      if (!p_cs && cfg_cs_n_o && rel_pending) begin
        hk_len = cyc - rel_cyc; rel_pending = 0;
        cs_gap_seen = !any_rise_since_rel;
      end
      if (s_ready_o) ready_seen = 1;
      if (s_ready_o && cfg_cs_n_o) chk(0, "R5 ready while deselected", 1, 0);
      if (s_valid_i && s_ready_o) begin
        if (hs_cnt != 0)
          chk(rises_since_hs == 8, "R5 eight edges between accepted bytes",
              rises_since_hs, 8);
        hs_cnt++; rises_since_hs = 0;
      end
      if (cfg_sck_o && !p_sck) begin
        any_rise_since_rel = 1;
        rises_since_hs++;
        if (bitpos != 0) chk(cyc - last_rise == 2*HALF, "R4 sck period",
                             cyc - last_rise, 2*HALF);
        last_rise = cyc;
        acc = {acc[6:0], cfg_mosi_o};
        bitpos++;
        if (bitpos == 8) begin
          bitpos = 0;
          if (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(acc == e, "R4 shifted byte", acc, e);
          end else begin
            act_cnt++;
            chk(acc == 8'h00, "R7 activation byte zero", acc, 0);
          end
        end
      end
    end
    p_rst = cfg_rst_n_o; p_cs = cfg_cs_n_o; p_sck = cfg_sck_o;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic pulse_start(input bit part);
    @(negedge clk);
    start_i = 1'b1; partial_i = part;
    @(negedge clk);
    start_i = 1'b0; partial_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last, input int gap);
    repeat (gap) @(negedge clk);
    s_valid_i = 1'b1; s_data_i = b; s_last_i = last;
    exp_q.push_back(b);
    while (!s_ready_o) @(negedge clk);
    @(negedge clk);
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  task automatic wait_end(output bit ok, output bit er, output int code);
    int n;
    n = 0;
    while (!(ok_o || err_o) && n < 20000) begin @(negedge clk); n++; end
    ok = ok_o; er = err_o; code = err_code_o;
    chk(busy_o == 1'b0, "R9 busy low with result", busy_o, 0);
  endtask

  initial begin
    bit ok, er;
    int code;
    rst_n = 1'b0; start_i = 0; partial_i = 0; s_valid_i = 0; s_data_i = 0;
    s_last_i = 0; cfg_done_i = 0;
    p_rst = 1; p_cs = 1; p_sck = 0; acc = 0; last_rise = 0; rel_cyc = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(busy_o == 0 && cfg_cs_n_o && cfg_rst_n_o && !cfg_sck_o && !s_ready_o,
        "R9 reset state", {busy_o, cfg_cs_n_o, cfg_rst_n_o, cfg_sck_o}, 4'b0110);

    // R8 partial request refused
    pulse_start(1'b1);
    chk(err_o && err_code_o == 2'd3, "R8 partial error code", {err_o, err_code_o}, 3'b111);
    chk(!busy_o && cfg_cs_n_o && cfg_rst_n_o, "R8 pins untouched",
        {busy_o, cfg_cs_n_o, cfg_rst_n_o}, 3'b011);
    repeat (5) @(negedge clk);
    chk(rst_falls == 0, "R8 no reset pulse", rst_falls, 0);

    // R2 reset failure: done stuck high
    clear_mon();
    cfg_done_i = 1'b1;
    pulse_start(1'b0);
    chk(busy_o == 1, "R9 busy after start", busy_o, 1);
    wait_end(ok, er, code);
    chk(er && code == 1, "R2 reset-failed code", code, 1);
    @(negedge clk);
    chk(cfg_cs_n_o == 1, "R2 cs released", cfg_cs_n_o, 1);
    chk(!ready_seen, "R2 no byte requested", ready_seen, 0);
    chk(rst_low_len >= RST_CYC, "R1 reset hold length", rst_low_len, RST_CYC);
    cfg_done_i = 1'b0;

    // R7 normal load with a second start ignored
    clear_mon();
    pulse_start(1'b0);
    chk(busy_o == 1, "R9 busy after start", busy_o, 1);
    fork
      begin repeat (40) @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; end
      begin
        send_byte(8'hA5, 0, 0); send_byte(8'h3C, 0, 0); send_byte(8'h00, 0, 0);
        send_byte(8'hFF, 0, 0); send_byte(8'h81, 1, 0);
        cfg_done_i = 1'b1;
      end
    join
    wait_end(ok, er, code);
    chk(ok && !er && code == 0, "R7 success", {ok, er, code[1:0]}, 4'b1000);
    chk(rst_low_len >= RST_CYC, "R1 reset hold length", rst_low_len, RST_CYC);
    chk(hk_len >= HK_CYC, "R3 housekeeping length", hk_len, HK_CYC);
    chk(cs_gap_seen, "R3 cs high before data", cs_gap_seen, 1);
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    chk(act_cnt == NACT, "R7 activation byte count", act_cnt, NACT);
    chk(rst_falls == 1, "R9 start while busy ignored", rst_falls, 1);
    @(negedge clk);
    chk(cfg_cs_n_o == 1, "R7 cs released", cfg_cs_n_o, 1);
    cfg_done_i = 1'b0;

    // R5 second load: gaps in the stream, counting pattern
    clear_mon();
    pulse_start(1'b0);
    for (int i = 0; i < 12; i++) send_byte(8'(i * 37 + 1), i == 11, i % 3);
    cfg_done_i = 1'b1;
    wait_end(ok, er, code);
    chk(ok && code == 0, "R5 gapped stream success", code, 0);
    chk(exp_q.size() == 0, "R5 all gapped bytes seen", exp_q.size(), 0);
    chk(hs_cnt == 12, "R5 handshake count", hs_cnt, 12);
    chk(act_cnt == NACT, "R7 activation count second load", act_cnt, NACT);
    cfg_done_i = 1'b0;

    // R6 target never reports done
    clear_mon();
    pulse_start(1'b0);
    send_byte(8'h5A, 0, 1); send_byte(8'hC3, 0, 0); send_byte(8'h7E, 1, 2);
    wait_end(ok, er, code);
    chk(er && code == 2, "R6 not-done code", code, 2);
    repeat (20) @(negedge clk);
    chk(act_cnt == 0 && bitpos == 0, "R6 no activation clocks", act_cnt, 0);
    chk(exp_q.size() == 0, "R6 data bytes still shifted", exp_q.size(), 0);
    chk(cfg_cs_n_o == 1 && busy_o == 0, "R6 released after error",
        {cfg_cs_n_o, busy_o}, 2'b10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule